// File: doc/BRIEF.md
# Armed-Write Byte Memory Controller

This block is the register front end of a small byte-wide nonvolatile data store held inside the chip. Software reaches it through four byte registers: an address pair, a data register and a control register. Reads are immediate. A read strobe copies the addressed byte into the data register, and the processor is then held for a few cycles. A write is guarded by a two-step unlock. First software sets an arm bit. A start request is honoured only while that arm is live, and the arm lapses by itself after four system cycles. Once a write starts, its duration is measured on a slow timing tick and not on the system clock. The address and data registers are frozen until the write finishes. No write can start while an outside flash self-programming job reports busy.

The behaviour sits in one state machine with three states. `ST_IDLE` moves to `ST_ARMED` on an arm request. `ST_ARMED` moves to `ST_PROGRAM` on a start request made while flash is not busy. A further arm request in `ST_ARMED` reloads the window and stays in `ST_ARMED`. When the window runs out, `ST_ARMED` returns to `ST_IDLE`. `ST_PROGRAM` returns to `ST_IDLE` on the cycle the tick counter reports completion, and the byte is committed to the array in that same cycle. Each start and each read loads a small stall counter, and that counter drives the processor hold line.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset every address, data and control bit reads 0, `cpu_stall` is low, and every cell of the array holds 0xFF.
- R2: The register select picks one register: 0 is the address low byte, 1 is the address high part (only bit 0 is stored; the other bits read 0), 2 is data and 3 is control. Control bit 0 is the read strobe, bit 1 is start/busy and bit 2 is arm.
- R3: A control write with bit 2 at 1 and bit 1 at 0 sets the arm bit. The arm bit clears itself four cycles after the arming write.
- R4: A control write with bit 1 at 1, made one to four cycles after the arming write, starts a write and busy reads 1. The same request five or more cycles later does nothing.
- R5: A start request is ignored while `flash_busy` is high.
- R6: Busy clears after `PROG_TICKS` pulses of `slow_tick`. The byte is then stored at the address held in the address registers.
- R7: A write that starts holds `cpu_stall` high for exactly two cycles.
- R8: A control write with bit 0 at 1 puts the addressed byte into the data register in the next cycle and holds `cpu_stall` high for exactly four cycles.
- R9: While busy is set, writes to the address and data registers have no effect and read strobes are ignored.
- R10: The read strobe bit reads 1 for the single cycle after the strobe and then 0.
- R11: A start request made without a live arm does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Selected register contents |
| flash_busy | input | 1 | Flash self-programming in progress |
| slow_tick | input | 1 | One-cycle pulse from the slow timing clock |
| cpu_stall | output | 1 | Processor hold request |

## Verification
The unlock-and-program sequence is driven from a table that sweeps the gap between the arm write and the start write from one to six cycles. Gaps of one to four tell an accepted start apart from gaps of five and six, which must leave busy, stall and the stored byte untouched. The table entries include the lowest and highest addresses and a rewrite of the same cell, so address decoding and overwriting are both visible. Directed cases then cover a start with no arm, a start blocked by flash busy, and register edits and read strobes made during programming.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam logic [1:0] SEL_ADDR_LO = 2'd0;
    localparam logic [1:0] SEL_ADDR_HI = 2'd1;
    localparam logic [1:0] SEL_DATA    = 2'd2;
    localparam logic [1:0] SEL_CTRL    = 2'd3;

    localparam int CB_READ  = 0;
    localparam int CB_START = 1;
    localparam int CB_ARM   = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PROGRAM = 2'd2
    } nvm_state_t;
endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int         DEPTH  = 512,
    parameter int         AW     = 9,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int TICKS = 8448
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (run && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] len,
    output logic          stall
);
    logic [SW-1:0] left;

    assign stall = (left != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     left <= '0;
        else if (load)  left <= len;
        else if (stall) left <= left - 1'b1;
    end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int DEPTH      = 512,
    parameter int PROG_TICKS = 8448,
    parameter int ARM_WINDOW = 4,
    parameter int RD_STALL   = 4,
    parameter int WR_STALL   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       flash_busy,
    input  logic       slow_tick,
    output logic       cpu_stall
);
    localparam int AW        = $clog2(DEPTH);
    localparam int AHW       = AW - 8;
    localparam int ACW       = (ARM_WINDOW > 1) ? $clog2(ARM_WINDOW) : 1;
    localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int SW        = $clog2(STALL_MAX + 1);

    nvm_state_t    state, state_nx;
    logic [ACW-1:0] arm_cnt;
    logic [AW-1:0]  addr_q;
    logic [7:0]     data_q;
    logic           rd_flag;
    logic [7:0]     cell_rd;

    logic ctrl_wr, arm_req, start_req, rd_req;
    logic armed_w, busy_w, start_go, prog_done, mem_we;

    // Bus decode
    assign ctrl_wr   = bus_we && (bus_sel == SEL_CTRL);
    assign arm_req   = ctrl_wr && bus_wdata[CB_ARM] && !bus_wdata[CB_START];
    assign start_req = ctrl_wr && bus_wdata[CB_START];
    assign rd_req    = ctrl_wr && bus_wdata[CB_READ] && !busy_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (arm_req) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (start_req && !flash_busy) state_nx = ST_PROGRAM;
                else if (arm_req)             state_nx = ST_ARMED;
                else if (arm_cnt == '0)       state_nx = ST_IDLE;
            end
            ST_PROGRAM: begin
                if (prog_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        armed_w  = 1'b0;
        busy_w   = 1'b0;
        start_go = 1'b0;
        mem_we   = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ARMED: begin
                armed_w  = 1'b1;
                start_go = start_req && !flash_busy;
            end
            ST_PROGRAM: begin
                busy_w = 1'b1;
                mem_we = prog_done;
            end
            default: ;
        endcase
    end

    // Arm window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            arm_cnt <= '0;
        else if (arm_req && !busy_w)           arm_cnt <= ACW'(ARM_WINDOW - 1);
        else if (armed_w && arm_cnt != '0)     arm_cnt <= arm_cnt - 1'b1;
    end

    // Address, data and strobe registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            rd_flag <= 1'b0;
        end else begin
            rd_flag <= rd_req;
            if (rd_req) data_q <= cell_rd;
            if (bus_we && !busy_w) begin
                if (bus_sel == SEL_ADDR_LO) addr_q[7:0]    <= bus_wdata;
                if (bus_sel == SEL_ADDR_HI) addr_q[AW-1:8] <= bus_wdata[AHW-1:0];
                if (bus_sel == SEL_DATA)    data_q         <= bus_wdata;
            end
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_sel)
            SEL_ADDR_LO: bus_rdata = addr_q[7:0];
            SEL_ADDR_HI: bus_rdata[AHW-1:0] = addr_q[AW-1:8];
            SEL_DATA:    bus_rdata = data_q;
            SEL_CTRL: begin
                bus_rdata[CB_READ]  = rd_flag;
                bus_rdata[CB_START] = busy_w;
                bus_rdata[CB_ARM]   = armed_w;
            end
            default: ;
        endcase
    end

    nvm_array #(.DEPTH(DEPTH), .AW(AW), .ERASED(8'hFF)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (cell_rd)
    );

    nvm_prog_timer #(.TICKS(PROG_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_go),
        .run   (busy_w),
        .tick  (slow_tick),
        .done  (prog_done)
    );

    nvm_stall_gen #(.SW(SW)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_go || rd_req),
        .len   (rd_req ? SW'(RD_STALL) : SW'(WR_STALL)),
        .stall (cpu_stall)
    );
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       armed_w,
    input logic       busy_w,
    input logic       rd_flag,
    input logic       cpu_stall,
    input logic       flash_busy,
    input logic [8:0] addr_q
);
    logic [3:0] arm_run;
    logic [3:0] stall_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_run   <= '0;
            stall_run <= '0;
        end else begin
            arm_run   <= armed_w   ? ((arm_run   == 4'hF) ? arm_run   : arm_run + 1'b1)   : 4'd0;
            stall_run <= cpu_stall ? ((stall_run == 4'hF) ? stall_run : stall_run + 1'b1) : 4'd0;
        end
    end

    assert_arm_lapses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_run <= 4'd4);

    assert_start_after_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> $past(armed_w));

    assert_flash_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> !$past(flash_busy));

    assert_start_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> cpu_stall);

    assert_stall_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= 4'd4);

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && $past(busy_w)) |-> $stable(addr_q));

    assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && $past(busy_w)) |-> !rd_flag);
endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed_w    (armed_w),
    .busy_w     (busy_w),
    .rd_flag    (rd_flag),
    .cpu_stall  (cpu_stall),
    .flash_busy (flash_busy),
    .addr_q     (addr_q)
);

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
    localparam int PT  = 6;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       flash_busy = 1'b0;
    logic       slow_tick = 1'b0;
    logic       cpu_stall;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [512];
    int tick_cnt = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt  <= 0;
            slow_tick <= 1'b0;
        end else begin
            tick_cnt  <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
            slow_tick <= (tick_cnt == DIV - 1);
        end
    end

    nvm_ctrl #(.PROG_TICKS(PT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_busy(flash_busy),
        .slow_tick(slow_tick), .cpu_stall(cpu_stall)
    );

    // {addr[8:0], data[7:0], gap[2:0], accepted}
    localparam logic [20:0] VEC [6] = '{
        {9'h000, 8'hA5, 3'd1, 1'b1},
        {9'h1FF, 8'h3C, 3'd4, 1'b1},
        {9'h100, 8'h00, 3'd5, 1'b0},
        {9'h0AB, 8'h5A, 3'd2, 1'b1},
        {9'h0AB, 8'hC3, 3'd3, 1'b1},
        {9'h155, 8'h77, 3'd6, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        bus_sel = s; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        bus_sel = s; #1; v = bus_rdata;
    endtask

    task automatic stall_len(output int n);
        n = 0;
        while (cpu_stall && n < 10) begin
            n++; @(posedge clk); #1;
        end
    endtask

    task automatic wait_busy(output int cyc);
        cyc = 0; bus_sel = 2'd3; #1;
        while (bus_rdata[1] && cyc < 1000) begin
            @(posedge clk); #1; cyc++;
        end
    endtask

    task automatic set_addr(input logic [8:0] a);
        wr(2'd0, a[7:0]);
        wr(2'd1, {7'd0, a[8]});
    endtask

    initial begin : watchdog
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int n;
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v); chk("R1 addr lo", v, 0);
        rd(2'd1, v); chk("R1 addr hi", v, 0);
        rd(2'd2, v); chk("R1 data", v, 0);
        rd(2'd3, v); chk("R1 ctrl", v, 0);
        chk("R1 stall", cpu_stall, 0);
        idle(1);
        set_addr(9'h1FE);
        wr(2'd3, 8'h01);
        stall_len(n);
        rd(2'd2, v); chk("R1 erased cell", v, 8'hFF);

        // R2 high address keeps only bit 0
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R2 addr hi mask", v, 8'h01);
        idle(1);

        // Table: arm-to-start gap sweep
        for (int k = 0; k < 6; k++) begin
            logic [8:0] a;
            logic [7:0] d;
            int gap;
            logic acc;
            int cyc;
            a = VEC[k][20:12]; d = VEC[k][11:4]; gap = int'(VEC[k][3:1]); acc = VEC[k][0];
            set_addr(a);
            wr(2'd2, d);
            wr(2'd3, 8'h04);
            rd(2'd3, v); chk("R3 arm set", v[2], 1);
            if (gap > 1) idle(gap - 1);
            rd(2'd3, v); chk("R3 arm before start", v[2], (gap <= 4) ? 1 : 0);
            wr(2'd3, 8'h02);
            rd(2'd3, v); chk("R4 busy after gap", v[1], acc);
            stall_len(n); chk("R7 write stall", n, acc ? 2 : 0);
            if (acc) begin
                wait_busy(cyc);
                n_tests++;
                if (cyc < (PT - 1) * DIV - 2 || cyc > PT * DIV + 1) begin
                    n_fail++;
                    $display("FAIL R6 busy cycles actual=%0d expected=%0d..%0d",
                             cyc, (PT - 1) * DIV - 2, PT * DIV + 1);
                end
                model[a] = d;
            end
            wr(2'd2, 8'hEE);
            wr(2'd3, 8'h01);
            rd(2'd3, v); chk("R10 strobe bit", v[0], 1);
            stall_len(n); chk("R8 read stall", n, 4);
            rd(2'd2, v); chk("R6 R8 readback", v, model[a]);
            rd(2'd3, v); chk("R10 strobe cleared", v[0], 0);
            idle(1);
        end

        // R11 start with no arm
        set_addr(9'h033);
        wr(2'd2, 8'h42);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R11 no arm busy", v[1], 0);
        chk("R11 no arm stall", cpu_stall, 0);
        idle(1);

        // R5 flash busy blocks start
        flash_busy = 1'b1;
        wr(2'd3, 8'h04);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R5 flash busy", v[1], 0);
        chk("R5 flash stall", cpu_stall, 0);
        flash_busy = 1'b0;
        idle(5);
        wr(2'd3, 8'h01);
        stall_len(n);
        rd(2'd2, v); chk("R5 cell untouched", v, 8'hFF);
        idle(1);

        // R9 register protection during programming
        set_addr(9'h010);
        wr(2'd2, 8'h99);
        wr(2'd3, 8'h04);
        wr(2'd3, 8'h02);
        stall_len(n);
        wr(2'd0, 8'h22);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h11);
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R9 strobe ignored", v[0], 0);
        chk("R9 no read stall", cpu_stall, 0);
        idle(1);
        rd(2'd0, v); chk("R9 addr lo held", v, 8'h10);
        rd(2'd1, v); chk("R9 addr hi held", v, 0);
        rd(2'd2, v); chk("R9 data held", v, 8'h99);
        wait_busy(n);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        stall_len(n);
        rd(2'd2, v); chk("R9 stored byte", v, 8'h99);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule